// File: doc/BRIEF.md
# Register-Driven Serial Peripheral Master

This block is a four-wire serial master: serial clock, active-low chip select, data out and data in. It runs a fixed-length transaction of two or three bytes. A host sets it up through a small register port and then starts it. Three data registers supply the outgoing bytes. When the transaction is a read, the same registers receive the incoming bytes. A control register holds four settings: the byte count, whether chip select is released between bytes, the serial clock period, and an interface enable. It also holds one bit that starts a transaction when written and reads back as the busy flag.

The first byte on the wire is a command byte. Its most significant bit marks a read (1) or a write (0), and seven address bits follow. The bus runs with the clock idling low. Output data changes on the falling clock edge, and input data is sampled on the rising edge. Every byte is sent most significant bit first.

The engine is a state machine with six states:

| State | Pins |
|-------|------|
| `S_IDLE` | chip select high, clock low, data out low |
| `S_LEAD` | chip select low, first bit set up, clock still low |
| `S_HIGH` | clock high; the input bit is captured on entry |
| `S_LOW` | clock low; the next bit is driven |
| `S_GAP` | chip select high for one full clock period between bytes |
| `S_TAIL` | chip select still low for half a period after the last bit |

The transitions are as follows. All of them except the start wait for the half-period tick.
- **Start:** `S_IDLE`→`S_LEAD`, on an enabled start write.
- **Setup done:** `S_LEAD`→`S_HIGH`.
- **Clock rise:** `S_LOW`→`S_HIGH`.
- **Clock fall:** `S_HIGH`→`S_LOW`, when bits remain in the byte, or at a byte boundary without a break.
- **Byte break:** `S_HIGH`→`S_GAP`, at a byte boundary when the break setting is on.
- **Break done:** `S_GAP`→`S_LEAD`, after two ticks.
- **Last bit:** `S_HIGH`→`S_TAIL`.
- **Release:** `S_TAIL`→`S_IDLE`.

Top module: `spi_regmaster`

## Requirements
- R1: After reset the pins are idle: `spi_cs_n`=1, `spi_sclk`=0 and `spi_mosi`=0. All four registers read 0.
- R2: Control bit 1 selects the transaction length. A value of 0 gives 2 bytes (16 clock pulses) and 1 gives 3 bytes (24 clock pulses).
- R3: Control bit 2 selects the chip select behaviour. When it is 0, chip select stays low from the first bit to the last. When it is 1, chip select goes high after each byte except the last, for exactly one serial clock period.
- R4: Control bit 0 is the start/busy bit. Writing 1 to it starts a transaction. Reading it returns 1 while the transaction runs and 0 once the block is idle.
- R5: Control bits [4:3] are the speed code. With the default HALF_CYC=16 and a 10 ns system clock, codes 0, 1, 2 and 3 give serial clock periods of 320, 640, 960 and 2560 ns.
- R6: Data registers 0, 1 and 2 (addresses 0–2) are sent as bytes 1, 2 and 3, each most significant bit first. Data out changes only while the clock falls or is low, and chip select falls only while the clock is low.
- R7: If bit 7 of data register 0 is 1 (read), the bytes received during bytes 2 and 3 are stored into data registers 1 and 2, and data register 0 is kept. If that bit is 0 (write), no data register changes.
- R8: Control bit 5 is the enable. A start write with the enable at 0 is ignored: the busy bit stays 0 and the pins stay idle.
- R9: While busy, host writes to any register are ignored.
- R10: Address 3 reads back as {2'b00, enable, speed[1:0], break, length, busy}.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0–2 data, 3 control) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| spi_sclk | output | 1 | Serial clock, idles low |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data to the peripheral |
| spi_miso | input | 1 | Serial data from the peripheral |

## Verification
The bench acts as a peripheral. It samples data out on rising clock edges and changes data in on falling edges and on chip select falls. It measures the clock period for every speed code and the width of the chip select break. A design that shifted on the wrong edge, or that sent least significant bit first, would corrupt the captured bytes. A design that miscounted the break or the last byte would show the wrong pulse count or the wrong chip select width. Read transactions check that bytes land in registers 1 and 2 and that register 0 survives. A two-byte read must leave register 2 alone. Write transactions must leave all data registers untouched. Further cases cover a start while disabled and register writes made in the middle of a transfer; a design that honoured either would start a spurious transaction or alter the bytes on the wire.

// File: rtl/spi_rm_pkg.sv
package spi_rm_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        S_IDLE,
        S_LEAD,
        S_HIGH,
        S_LOW,
        S_GAP,
        S_TAIL
    } spi_state_t;

    // Half-period multiplier selected by the speed code
    function automatic int half_mult(input logic [1:0] code);
        case (code)
            2'd0:    return 1;
            2'd1:    return 2;
            2'd2:    return 3;
            default: return 8;
        endcase
    endfunction

endpackage

// File: rtl/spi_rm_clkdiv.sv
module spi_rm_clkdiv #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [CW-1:0] half_len,
    output logic          tick
);

    logic [CW-1:0] cnt;

    assign tick = run && (cnt == half_len - 1'b1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (!run || tick)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    // Counter restarts from zero whenever the engine is not running (R5)
    p_cnt_cleared_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> cnt == '0);

endmodule

// File: rtl/spi_rm_regs.sv
module spi_rm_regs
    import spi_rm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [1:0]        addr_i,
    input  logic [BYTE_W-1:0] wdata_i,
    output logic [BYTE_W-1:0] rdata_o,
    input  logic              busy_i,
    input  logic              cap_we_i,
    input  logic [1:0]        cap_idx_i,
    input  logic [BYTE_W-1:0] cap_data_i,
    output logic [BYTE_W-1:0] tx0_o,
    output logic [BYTE_W-1:0] tx1_o,
    output logic [BYTE_W-1:0] tx2_o,
    output logic              len3_o,
    output logic              brk_o,
    output logic [1:0]        spd_o,
    output logic              start_o
);

    localparam int NDATA = 3;

    logic [BYTE_W-1:0] data_q [NDATA];
    logic              en_q;
    logic              host_ok;

    assign host_ok = we_i && !busy_i;

    for (genvar i = 0; i < NDATA; i++) begin : g_data
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                data_q[i] <= '0;
            else if (host_ok && addr_i == 2'(i))
                data_q[i] <= wdata_i;
            else if (cap_we_i && cap_idx_i == 2'(i))
                data_q[i] <= cap_data_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            len3_o <= 1'b0;
            brk_o  <= 1'b0;
            spd_o  <= 2'd0;
            en_q   <= 1'b0;
        end else if (host_ok && addr_i == 2'd3) begin
            len3_o <= wdata_i[1];
            brk_o  <= wdata_i[2];
            spd_o  <= wdata_i[4:3];
            en_q   <= wdata_i[5];
        end
    end

    assign start_o = host_ok && addr_i == 2'd3 && wdata_i[0] && wdata_i[5];
    assign tx0_o   = data_q[0];
    assign tx1_o   = data_q[1];
    assign tx2_o   = data_q[2];

    always_comb begin
        unique case (addr_i)
            2'd0:    rdata_o = data_q[0];
            2'd1:    rdata_o = data_q[1];
            2'd2:    rdata_o = data_q[2];
            default: rdata_o = {2'b00, en_q, spd_o, brk_o, len3_o, busy_i};
        endcase
    end

    p_capture_only_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cap_we_i |-> busy_i);

    p_ctrl_locked_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_i && we_i && addr_i == 2'd3) |=> $stable({en_q, spd_o, brk_o, len3_o}));

endmodule

// File: rtl/spi_rm_fsm.sv
module spi_rm_fsm
    import spi_rm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              tick_i,
    input  logic              len3_i,
    input  logic              brk_i,
    input  logic [BYTE_W-1:0] tx0_i,
    input  logic [BYTE_W-1:0] tx1_i,
    input  logic [BYTE_W-1:0] tx2_i,
    input  logic              miso_i,
    output logic              busy_o,
    output logic              sclk_o,
    output logic              cs_n_o,
    output logic              mosi_o,
    output logic              cap_we_o,
    output logic [1:0]        cap_idx_o,
    output logic [BYTE_W-1:0] cap_data_o
);

    localparam int BCW = $clog2(BYTE_W);

    spi_state_t        state, state_nx;
    logic [BYTE_W-1:0] shreg, rxreg;
    logic [BCW-1:0]    bit_cnt;
    logic [1:0]        byte_idx;
    logic              gap_second;
    logic              is_read;
    logic              last_byte;
    logic              byte_end;

    assign last_byte = byte_idx == (len3_i ? 2'd2 : 2'd1);
    assign byte_end  = bit_cnt == '0;

    function automatic logic [BYTE_W-1:0] pick(input logic [1:0] idx,
                                               input logic [BYTE_W-1:0] b0,
                                               input logic [BYTE_W-1:0] b1,
                                               input logic [BYTE_W-1:0] b2);
        case (idx)
            2'd0:    return b0;
            2'd1:    return b1;
            default: return b2;
        endcase
    endfunction

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE: if (start_i) state_nx = S_LEAD;
            S_LEAD: if (tick_i)  state_nx = S_HIGH;
            S_LOW:  if (tick_i)  state_nx = S_HIGH;
            S_HIGH: if (tick_i) begin
                if (!byte_end)      state_nx = S_LOW;
                else if (last_byte) state_nx = S_TAIL;
                else if (brk_i)     state_nx = S_GAP;
                else                state_nx = S_LOW;
            end
            S_GAP:  if (tick_i && gap_second) state_nx = S_LEAD;
            S_TAIL: if (tick_i)  state_nx = S_IDLE;
            default:             state_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state      <= S_IDLE;
            shreg      <= '0;
            rxreg      <= '0;
            bit_cnt    <= '0;
            byte_idx   <= '0;
            gap_second <= 1'b0;
            is_read    <= 1'b0;
        end else begin
            state <= state_nx;
            if (state == S_IDLE && start_i) begin
                shreg      <= tx0_i;
                bit_cnt    <= BCW'(BYTE_W - 1);
                byte_idx   <= '0;
                gap_second <= 1'b0;
                is_read    <= tx0_i[BYTE_W-1];
            end
            if ((state == S_LEAD || state == S_LOW) && tick_i)
                rxreg <= {rxreg[BYTE_W-2:0], miso_i};
            if (state == S_HIGH && tick_i) begin
                if (!byte_end) begin
                    shreg   <= {shreg[BYTE_W-2:0], 1'b0};
                    bit_cnt <= bit_cnt - 1'b1;
                end else begin
                    byte_idx <= byte_idx + 1'b1;
                    bit_cnt  <= BCW'(BYTE_W - 1);
                    if (!last_byte && !brk_i)
                        shreg <= pick(byte_idx + 1'b1, tx0_i, tx1_i, tx2_i);
                end
            end
            if (state == S_GAP && tick_i) begin
                gap_second <= !gap_second;
                if (gap_second)
                    shreg <= pick(byte_idx, tx0_i, tx1_i, tx2_i);
            end
        end
    end

    always_comb begin
        busy_o = 1'b1;
        sclk_o = 1'b0;
        cs_n_o = 1'b0;
        mosi_o = 1'b0;
        unique case (state)
            S_IDLE: begin
                busy_o = 1'b0;
                cs_n_o = 1'b1;
            end
            S_LEAD, S_LOW: mosi_o = shreg[BYTE_W-1];
            S_HIGH: begin
                sclk_o = 1'b1;
                mosi_o = shreg[BYTE_W-1];
            end
            S_GAP:  cs_n_o = 1'b1;
            S_TAIL: ;
            default: cs_n_o = 1'b1;
        endcase
    end

    assign cap_we_o   = state == S_HIGH && tick_i && byte_end && is_read && byte_idx != 2'd0;
    assign cap_idx_o  = byte_idx;
    assign cap_data_o = rxreg;

    p_idle_pins_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (cs_n_o && !sclk_o && !mosi_o));

    p_clk_inside_cs_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_o |-> !cs_n_o);

    p_cs_falls_clk_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n_o) |-> !sclk_o);

    p_mosi_stable_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_o && $past(sclk_o)) |-> $stable(mosi_o));

    p_capture_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cap_we_o |-> (cap_idx_o <= (len3_i ? 2'd2 : 2'd1)));

endmodule

// File: rtl/spi_regmaster.sv
module spi_regmaster
    import spi_rm_pkg::*;
#(
    parameter int HALF_CYC = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_we,
    input  logic [1:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       spi_sclk,
    output logic       spi_cs_n,
    output logic       spi_mosi,
    input  logic       spi_miso
);

    localparam int CW = $clog2(HALF_CYC * 8 + 1);

    logic              busy, start, tick, len3, brk;
    logic [1:0]        spd;
    logic [BYTE_W-1:0] tx0, tx1, tx2, cap_data;
    logic              cap_we;
    logic [1:0]        cap_idx;
    logic [CW-1:0]     half_len;

    assign half_len = CW'(HALF_CYC * half_mult(spd));

    spi_rm_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .we_i       (reg_we),
        .addr_i     (reg_addr),
        .wdata_i    (reg_wdata),
        .rdata_o    (reg_rdata),
        .busy_i     (busy),
        .cap_we_i   (cap_we),
        .cap_idx_i  (cap_idx),
        .cap_data_i (cap_data),
        .tx0_o      (tx0),
        .tx1_o      (tx1),
        .tx2_o      (tx2),
        .len3_o     (len3),
        .brk_o      (brk),
        .spd_o      (spd),
        .start_o    (start)
    );

    spi_rm_clkdiv #(.CW(CW)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (busy),
        .half_len (half_len),
        .tick     (tick)
    );

    spi_rm_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start),
        .tick_i     (tick),
        .len3_i     (len3),
        .brk_i      (brk),
        .tx0_i      (tx0),
        .tx1_i      (tx1),
        .tx2_i      (tx2),
        .miso_i     (spi_miso),
        .busy_o     (busy),
        .sclk_o     (spi_sclk),
        .cs_n_o     (spi_cs_n),
        .mosi_o     (spi_mosi),
        .cap_we_o   (cap_we),
        .cap_idx_o  (cap_idx),
        .cap_data_o (cap_data)
    );

    p_start_needs_enable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && reg_we && reg_addr == 2'd3 && !reg_wdata[5]) |=> !busy);

    p_start_sets_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && reg_we && reg_addr == 2'd3 && reg_wdata[0] && reg_wdata[5]) |=> busy);

endmodule

// File: tb/spi_regmaster_test.sv
`timescale 1ns/1ps
module spi_regmaster_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_we = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       spi_sclk, spi_cs_n, spi_mosi;
    logic       spi_miso = 1'b0;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    spi_regmaster uut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_sclk(spi_sclk),
        .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    // Peripheral model
    logic [23:0] s_pat = '0;
    logic [31:0] s_rx = '0;
    int  s_idx = 0, s_clks = 0, s_csr = 0;
    time t1 = 0, t2 = 0, t_csr = 0, s_gap = 0;

    always @(negedge spi_cs_n or negedge spi_sclk)
        if (s_idx < 24) spi_miso = s_pat[23 - s_idx];

    always @(negedge spi_cs_n)
        if (t_csr != 0) s_gap = $time - t_csr;

    always @(posedge spi_cs_n) begin
        s_csr++;
        t_csr = $time;
    end

    always @(posedge spi_sclk) begin
        s_rx = {s_rx[30:0], spi_mosi};
        s_clks++;
        if (s_clks == 1) t1 = $time;
        if (s_clks == 2) t2 = $time;
        s_idx++;
    end

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic slave_clear(input logic [23:0] pat);
        s_pat = pat; s_rx = '0; s_idx = 0; s_clks = 0; s_csr = 0;
        t1 = 0; t2 = 0; t_csr = 0; s_gap = 0;
    endtask

    task automatic wait_idle(output bit ok);
        logic [7:0] v;
        ok = 0;
        for (int i = 0; i < 20000; i++) begin
            rd(2'd3, v);
            if (!v[0]) begin ok = 1; break; end
        end
    endtask

    // {len3, brk, spd[1:0], d0, d1, d2, miso pattern}
    localparam logic [51:0] VEC [0:5] = '{
        {1'b0, 1'b0, 2'd0, 8'h5A, 8'hC3, 8'h11, 24'hFFFFFF},
        {1'b1, 1'b0, 2'd1, 8'h81, 8'h00, 8'h00, 24'h00A53C},
        {1'b1, 1'b1, 2'd2, 8'h7E, 8'h96, 8'h24, 24'h123456},
        {1'b0, 1'b1, 2'd3, 8'hC5, 8'h3F, 8'h77, 24'hAA6E00},
        {1'b1, 1'b1, 2'd0, 8'hB0, 8'h01, 8'h80, 24'h5599CC},
        {1'b0, 1'b0, 2'd2, 8'h01, 8'hFE, 8'h5A, 24'h0F0F0F}
    };

    initial begin
        #2_000_000;
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        bit ok;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check(spi_cs_n === 1'b1 && spi_sclk === 1'b0 && spi_mosi === 1'b0, "R1 idle pins",
              {spi_cs_n, spi_sclk, spi_mosi}, 3'b100);
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), v);
            check(v === 8'h00, "R1 reset register", v, 0);
        end

        // Table-driven transactions: R2 R3 R4 R5 R6 R7 R10
        for (int k = 0; k < 6; k++) begin
            logic        len3, brk, rdop;
            logic [1:0]  spd;
            logic [7:0]  d0, d1, d2, e1, e2;
            logic [23:0] pat;
            logic [7:0]  ctrl;
            time         per;
            int          nb;
            {len3, brk, spd, d0, d1, d2, pat} = VEC[k];
            rdop = d0[7];
            nb = len3 ? 3 : 2;
            per = time'((spd == 2'd3 ? 8 : spd + 1) * 320);
            ctrl = {2'b00, 1'b1, spd, brk, len3, 1'b1};
            wr(2'd0, d0); wr(2'd1, d1); wr(2'd2, d2);
            slave_clear(pat);
            wr(2'd3, ctrl);
            rd(2'd3, v);
            check(v[0] === 1'b1, "R4 busy reads 1", v[0], 1);
            wait_idle(ok);
            check(ok, "R4 busy returns to 0", ok, 1);
            check(s_clks == nb * 8, "R2 clock pulse count", s_clks, nb * 8);
            if (len3)
                check(s_rx[23:0] === {d0, d1, d2}, "R6 bytes on data out", s_rx[23:0], {d0, d1, d2});
            else
                check(s_rx[15:0] === {d0, d1}, "R6 bytes on data out", s_rx[15:0], {d0, d1});
            check(t2 - t1 == per, "R5 clock period", t2 - t1, per);
            check(s_csr == (brk ? nb : 1), "R3 chip select releases", s_csr, brk ? nb : 1);
            if (brk)
                check(s_gap == per, "R3 break width", s_gap, per);
            e1 = rdop ? pat[15:8] : d1;
            e2 = (rdop && len3) ? pat[7:0] : d2;
            rd(2'd0, v); check(v === d0, "R7 register 0 kept", v, d0);
            rd(2'd1, v); check(v === e1, "R7 register 1", v, e1);
            rd(2'd2, v); check(v === e2, "R7 register 2", v, e2);
            rd(2'd3, v); check(v === {ctrl[7:1], 1'b0}, "R10 control readback", v, {ctrl[7:1], 1'b0});
        end

        // R8: start while disabled is ignored
        slave_clear(24'h0);
        wr(2'd3, 8'h03);
        rd(2'd3, v);
        check(v[0] === 1'b0, "R8 busy stays 0", v[0], 0);
        repeat (100) @(negedge clk);
        check(s_clks == 0 && spi_cs_n === 1'b1, "R8 pins idle", s_clks, 0);

        // R9: writes during busy are ignored
        wr(2'd0, 8'h22); wr(2'd1, 8'h33); wr(2'd2, 8'h44);
        slave_clear(24'h0);
        wr(2'd3, 8'h23);
        wr(2'd1, 8'hEE);
        wr(2'd3, 8'h00);
        wait_idle(ok);
        check(s_rx[23:0] === 24'h223344, "R9 bytes sent unchanged", s_rx[23:0], 24'h223344);
        check(s_clks == 24, "R9 length unchanged", s_clks, 24);
        rd(2'd1, v); check(v === 8'h33, "R9 data register kept", v, 8'h33);
        rd(2'd3, v); check(v === 8'h22, "R9 control kept", v, 8'h22);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule